// File: doc/BRIEF.md
# Programmable Countdown Timer with Prescaler

The block is a countdown timer whose count width is a parameter (32 bits by default). Software loads an initial count, a divide configuration and a vector entry. The vector entry holds an interrupt vector, a mask flag and a periodic flag. A free-running prescaler produces ticks at the clock rate divided by a power of two, and the count steps down by one on each tick.

In one-shot mode the count stops at zero. In periodic mode it reloads the initial value on the tick after it reaches zero. Each time the count reaches zero, the block raises a one-cycle request that carries the programmed vector, unless the entry is masked.

Writing the initial count reloads the count and restarts the prescaler at once. A zero initial count leaves the timer idle. Interrupt acceptance and register address decoding belong to neighbouring blocks.

Top module: `pdiv_timer`

## Requirements
- R1: A write to the divide configuration keeps only bits 0, 1 and 3 of `div_wdata`; bit 2 always reads back as 0 on `div_cfg`, and reset gives 0.
- R2: The divide code is {cfg[3], cfg[1], cfg[0]} (cfg[3] most significant) and the prescale shift is (code + 1) mod 8, so one tick comes every 2^shift clocks; code 7 divides by 1 and code 0 divides by 2.
- R3: In one-shot mode (`lvt_periodic` = 0), after an initial-count write of N the count reads N, falls by one per tick, reaches 0 after N ticks and then stays at 0.
- R4: In periodic mode the count reaches 0 after N ticks, reloads N on the next tick, and repeats with a period of N + 1 ticks.
- R5: A write of the initial count sets `cur_count` to the written value on the next cycle and restarts the prescaler, so the first tick after the write comes 2^shift clocks later, whatever count was running before.
- R6: In the cycle after the count steps to 0, `irq_req` is 1 for exactly one cycle and `irq_vec` equals the programmed `lvt_vector`; at all other times `irq_req` is 0.
- R7: While the stored mask flag is 1 (the reset value), no request is raised, but the count still runs.
- R8: The stored `lvt_periodic` flag selects periodic (1) or one-shot (0) behaviour.
- R9: An initial count of 0 keeps `cur_count` at 0 and never raises `irq_req`.
- R10: A change of divide configuration does not reload or reset the count; the new rate applies from the next prescaler boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icnt_we | input | 1 | Write strobe for the initial count |
| icnt_wdata | input | CNT_W | Initial count value |
| div_we | input | 1 | Write strobe for the divide configuration |
| div_wdata | input | 4 | Divide configuration value |
| lvt_we | input | 1 | Write strobe for the vector entry |
| lvt_vector | input | VEC_W | Interrupt vector to request on expiry |
| lvt_mask | input | 1 | 1 suppresses requests |
| lvt_periodic | input | 1 | 1 selects periodic mode |
| cur_count | output | CNT_W | Current count |
| div_cfg | output | 4 | Stored divide configuration |
| irq_req | output | 1 | One-cycle expiry request |
| irq_vec | output | VEC_W | Vector carried with the request |

## Verification
The bench compares the count in every cycle of each run against a value it computes from the tick index. Runs cover each divide code, both modes, and masked and unmasked entries. Directed runs with code 7 and code 0 tell the two ends of the shift mapping apart. A periodic run tells reload-on-zero from a hold at zero, and masked runs show the count moving while no request appears. The remaining patterns target single corner cases: a zero count, a reload in the middle of a run, and a divide change in the middle of a run. They separate a true restart from a prescaler that keeps its phase, and a pure rate change from a change that resets the count.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int DIV_W   = 4;
  localparam int CODE_W  = 3;
  localparam logic [DIV_W-1:0] DIV_KEEP = 4'hB;

  // R2: shift is code plus one, wrapping in the 3-bit field
  function automatic logic [CODE_W-1:0] shift_of(input logic [CODE_W-1:0] code);
    return code + 3'd1;
  endfunction
endpackage

// File: rtl/pdiv_prescale.sv
module pdiv_prescale #(
  parameter int SHIFT_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  assign mask = ~({PRE_W{1'b1}} << shift);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pcnt <= '0;
    end else begin
      pcnt <= pcnt + 1'b1;
    end
  end

  // R10: rate follows the live mask, phase is never reset by a divide change
  assign tick = (pcnt & mask) == mask;
endmodule

// File: rtl/pdiv_counter.sv
module pdiv_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  input  logic             periodic,
  output logic [CNT_W-1:0] count,
  output logic             expire
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] reload;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      reload <= '0;
    end else if (load) begin
      count  <= load_val;
      reload <= load_val;
    end else if (tick) begin
      if (count != '0) begin
        count <= count - ONE;
      end else if (periodic) begin
        count <= reload;
      end
    end
  end

  assign expire = tick && !load && (count == ONE);
endmodule

// File: rtl/pdiv_deliver.sv
module pdiv_deliver #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             expire,
  input  logic             masked,
  input  logic [VEC_W-1:0] vec_in,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_req <= expire && !masked;
      if (expire && !masked) begin
        irq_vec <= vec_in;
      end
    end
  end
endmodule

// File: rtl/pdiv_timer.sv
module pdiv_timer #(
  parameter int CNT_W = 32,
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             icnt_we,
  input  logic [CNT_W-1:0] icnt_wdata,
  input  logic             div_we,
  input  logic [3:0]       div_wdata,
  input  logic             lvt_we,
  input  logic [VEC_W-1:0] lvt_vector,
  input  logic             lvt_mask,
  input  logic             lvt_periodic,
  output logic [CNT_W-1:0] cur_count,
  output logic [3:0]       div_cfg,
  output logic             irq_req,
  output logic [VEC_W-1:0] irq_vec
);
  import pdiv_pkg::*;

  logic [DIV_W-1:0]  div_q;
  logic [VEC_W-1:0]  lvt_vec_q;
  logic              lvt_mask_q;
  logic              lvt_per_q;
  logic [CODE_W-1:0] shift;
  logic              tick;
  logic              expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      div_q      <= '0;
      lvt_vec_q  <= '0;
      lvt_mask_q <= 1'b1;
      lvt_per_q  <= 1'b0;
    end else begin
      if (div_we) begin
        div_q <= div_wdata & DIV_KEEP;   // R1
      end
      if (lvt_we) begin
        lvt_vec_q  <= lvt_vector;
        lvt_mask_q <= lvt_mask;
        lvt_per_q  <= lvt_periodic;      // R8
      end
    end
  end

  assign shift   = shift_of({div_q[3], div_q[1:0]});
  assign div_cfg = div_q;

  pdiv_prescale #(.SHIFT_W(CODE_W)) u_pre (
    .clk(clk), .rst(rst), .restart(icnt_we), .shift(shift), .tick(tick)
  );

  pdiv_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(icnt_we), .load_val(icnt_wdata),
    .tick(tick), .periodic(lvt_per_q), .count(cur_count), .expire(expire)
  );

  pdiv_deliver #(.VEC_W(VEC_W)) u_dlv (
    .clk(clk), .rst(rst), .expire(expire), .masked(lvt_mask_q),
    .vec_in(lvt_vec_q), .irq_req(irq_req), .irq_vec(irq_vec)
  );
endmodule

// File: rtl/pdiv_timer_chk.sv
module pdiv_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             icnt_we,
  input logic [CNT_W-1:0] icnt_wdata,
  input logic             lvt_we,
  input logic [CNT_W-1:0] cur_count,
  input logic             irq_req,
  input logic             expire,
  input logic             lvt_mask_q,
  input logic             lvt_per_q
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    irq_req |=> !irq_req);

  a_r6_count_zero: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (cur_count == '0));

  a_r3_hold_zero: assert property (@(posedge clk) disable iff (rst)
    (!icnt_we && !lvt_we && !lvt_per_q && cur_count == '0) |=> (cur_count == '0));

  a_r3_step_one: assert property (@(posedge clk) disable iff (rst)
    (!icnt_we && cur_count != '0) |=>
      (cur_count == $past(cur_count) || cur_count == $past(cur_count) - ONE));

  a_r7_masked: assert property (@(posedge clk) disable iff (rst)
    (expire && lvt_mask_q) |=> !irq_req);

  a_r9_zero_load: assert property (@(posedge clk) disable iff (rst)
    (icnt_we && icnt_wdata == '0) |=> (cur_count == '0 && !irq_req));

  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    icnt_we |=> (cur_count == $past(icnt_wdata)));
endmodule

bind pdiv_timer pdiv_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .icnt_we(icnt_we), .icnt_wdata(icnt_wdata),
  .lvt_we(lvt_we), .cur_count(cur_count), .irq_req(irq_req),
  .expire(expire), .lvt_mask_q(lvt_mask_q), .lvt_per_q(lvt_per_q)
);

// File: tb/test_pdiv_timer.sv
module test_pdiv_timer;
  localparam int CNT_W = 32;
  localparam int VEC_W = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             icnt_we = 1'b0;
  logic [CNT_W-1:0] icnt_wdata = '0;
  logic             div_we = 1'b0;
  logic [3:0]       div_wdata = '0;
  logic             lvt_we = 1'b0;
  logic [VEC_W-1:0] lvt_vector = '0;
  logic             lvt_mask = 1'b1;
  logic             lvt_periodic = 1'b0;
  logic [CNT_W-1:0] cur_count;
  logic [3:0]       div_cfg;
  logic             irq_req;
  logic [VEC_W-1:0] irq_vec;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pdiv_timer #(.CNT_W(CNT_W), .VEC_W(VEC_W)) i_pdiv_timer (
    .clk(clk), .rst(rst), .icnt_we(icnt_we), .icnt_wdata(icnt_wdata),
    .div_we(div_we), .div_wdata(div_wdata), .lvt_we(lvt_we),
    .lvt_vector(lvt_vector), .lvt_mask(lvt_mask), .lvt_periodic(lvt_periodic),
    .cur_count(cur_count), .div_cfg(div_cfg), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int unsigned shift_for(input logic [3:0] cfg);
    logic [2:0] c;
    c = {cfg[3], cfg[1:0]};
    c = c + 3'd1;
    return int'(c);
  endfunction

  task automatic wr_div(input logic [3:0] v);
    @(negedge clk);
    div_we = 1'b1; div_wdata = v;
    @(negedge clk);
    div_we = 1'b0;
  endtask

  task automatic wr_lvt(input logic [7:0] vec, input bit m, input bit per);
    @(negedge clk);
    lvt_we = 1'b1; lvt_vector = vec; lvt_mask = m; lvt_periodic = per;
    @(negedge clk);
    lvt_we = 1'b0;
  endtask

  task automatic wr_icnt(input int unsigned n);
    @(negedge clk);
    icnt_we = 1'b1; icnt_wdata = n;
    @(negedge clk);
    icnt_we = 1'b0;
  endtask

  // starts at the negedge right after the load edge (k = 0)
  task automatic run_window(input int unsigned n, input logic [3:0] cfg, input bit per,
                            input bit m, input logic [7:0] vec,
                            input string tagc, input string tagi);
    int unsigned s, kmax;
    s = shift_for(cfg);
    kmax = (n == 0) ? 300 : ((1 << s) * (per ? (2 * n + 3) : (n + 3)));
    for (int unsigned k = 0; k <= kmax; k++) begin
      int unsigned d, ec;
      bit ei;
      d  = k >> s;
      ec = 0;
      ei = 1'b0;
      if (n != 0) begin
        if (per) ec = n - (d % (n + 1));
        else     ec = (d >= n) ? 0 : n - d;
        ei = !m && (k % (1 << s) == 0) && (d >= 1) &&
             (per ? ((d % (n + 1)) == n) : (d == n));
      end
      chk(cur_count == ec, tagc, cur_count, ec);
      chk(irq_req == ei, tagi, irq_req, ei);
      if (ei) chk(irq_vec == vec, "R6 vector", irq_vec, vec);
      @(negedge clk);
    end
  endtask

  task automatic trial(input int unsigned n, input logic [3:0] cfg, input bit per,
                       input bit m, input logic [7:0] vec,
                       input string tagc, input string tagi);
    wr_div(cfg);
    wr_lvt(vec, m, per);
    wr_icnt(n);
    run_window(n, cfg, per, m, vec, tagc, tagi);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired (all requirements) actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [CNT_W-1:0] c0, c1;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    chk(cur_count == 0, "R3 reset count", cur_count, 0);
    chk(irq_req == 0, "R6 reset request", irq_req, 0);
    chk(div_cfg == 0, "R1 reset divide", div_cfg, 0);
    rst = 1'b0;
    @(negedge clk);

    // R1: masked storage of the divide configuration
    wr_div(4'hF);
    chk(div_cfg == 4'hB, "R1 keep bits 0,1,3", div_cfg, 4'hB);
    wr_div(4'h4);
    chk(div_cfg == 4'h0, "R1 drop bit 2", div_cfg, 4'h0);

    // R2 code 7: divide by 1, one-shot
    trial(5, 4'hB, 1'b0, 1'b0, 8'h42, "R2 R3 code7", "R6");
    // R2 code 0: divide by 2, periodic
    trial(3, 4'h0, 1'b1, 1'b0, 8'h81, "R2 R4 R8 code0", "R6");
    // R7: masked periodic, count still runs
    trial(4, 4'h1, 1'b1, 1'b1, 8'h13, "R7 R4 count", "R7");
    // R9: zero initial count
    trial(0, 4'hB, 1'b1, 1'b0, 8'h22, "R9 count", "R9");

    // R5: reload in the middle of a run
    wr_div(4'h1);
    wr_lvt(8'h5A, 1'b0, 1'b0);
    wr_icnt(10);
    repeat (5) @(negedge clk);
    wr_icnt(7);
    run_window(7, 4'h1, 1'b0, 1'b0, 8'h5A, "R5 restart", "R5 R6");

    // R10: divide change keeps the count
    wr_div(4'h2);
    wr_lvt(8'h66, 1'b0, 1'b0);
    wr_icnt(50);
    repeat (20) @(negedge clk);
    c0 = cur_count;
    chk(c0 == 48, "R10 before change", c0, 48);
    wr_div(4'hB);
    c1 = cur_count;
    chk((c1 <= c0) && (c1 + 1 >= c0), "R10 no reset", c1, c0);
    @(negedge clk);
    chk(cur_count == c1 - 1, "R10 new rate", cur_count, c1 - 1);

    // random trials
    for (int t = 0; t < 10; t++) begin
      int unsigned n;
      logic [3:0] cfg;
      bit per, m;
      logic [7:0] vec;
      n   = $urandom_range(1, 20);
      cfg = 4'($urandom_range(0, 15));
      per = 1'($urandom_range(0, 1));
      m   = ($urandom_range(0, 3) == 0);
      vec = 8'($urandom_range(0, 255));
      trial(n, cfg, per, m, vec, per ? "R4 R2 random" : "R3 R2 random",
            m ? "R7 random" : "R6 random");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule